// File: doc/BRIEF.md
# VGA Legacy Register Shadow

This block stands in for the standard VGA register set on a host that has no real VGA decode. Option firmware that expects to program a display controller through I/O ports can run unchanged. The block answers every byte port from 0x3C0 up to 0x3DA and keeps its own copy of what the firmware writes. Video is never produced from these values.

The shadow holds four indexed controllers, each with an index register and a small register array: attribute, sequencer, graphics and CRT. It also holds the miscellaneous output register, a pixel mask byte and a 768-byte colour table with separate read and write pointers. A status byte changes value on every read so that polling loops finish.

The attribute controller has a single port that is an index on one access and data on the next. A read of the status port puts it back to the index phase. A 16-bit write is applied as two byte writes to consecutive ports in consecutive cycles.

Top module: `vga_reg_shadow`

## Requirements
- R1: After reset every index register, the miscellaneous output, the pixel mask, the status byte, both colour table pointers, the attribute phase flip-flop and `rd_data` are zero.
- R2: A read issued with `rd_en` in one cycle shows its byte on `rd_data` after the next rising edge. `rd_data` holds that byte until the next read.
- R3: Every access to 0x3C0, read or write, toggles the attribute phase. In index phase (phase 0) a write loads the attribute index and a read returns it. In data phase a write stores into the attribute array at the index and a read returns that entry.
- R4: A read of 0x3C1 returns the attribute entry at the current index and leaves the phase unchanged. Writes to 0x3C1 are ignored.
- R5: A read of 0x3DA returns the status byte, forces the attribute phase to index, and then XORs the status byte with 0x09. Starting from reset, successive reads return 0x00, 0x09, 0x00.
- R6: The sequencer index at 0x3C4 and the graphics index at 0x3CE are readable and writable. Data at 0x3C5 and 0x3CF reads and writes the array entry that the index selects.
- R7: The array depths are 21 attribute, 5 sequencer, 9 graphics and 25 CRT entries. When the index is at or beyond the depth, a data write is ignored and a data read returns 0xFF.
- R8: The miscellaneous output is written at 0x3C2 and read at 0x3CC. The pixel mask is read and written at 0x3C6.
- R9: The CRT index (0x3D4) and CRT data (0x3D5) respond only while bit 0 of the miscellaneous output is 1. While that bit is 0, writes to them are ignored and reads return 0xFF.
- R10: A write of v to 0x3C7 sets the read pointer to 3·v, and a write of v to 0x3C8 sets the write pointer to 3·v. Reads of 0x3C7 and 0x3C8 return bits 7:0 of the read and write pointer.
- R11: A write to 0x3C9 stores the byte at the write pointer and then increments the pointer. A read of 0x3C9 returns the byte at the read pointer and then increments the pointer. Once a pointer has reached 768, the access is ignored, the pointer stays at 768, and a read returns 0xFF.
- R12: A read of a port the block does not handle returns 0xFF and changes nothing. This covers ports inside the range such as 0x3C2 and 0x3CA, and ports outside it. A write to such a port changes nothing.
- R13: With `wr_word` set, a write sends `wr_data[7:0]` to the port and then, one cycle later, `wr_data[15:8]` to the port plus one. The host leaves the cycle after a word write idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| wr_word | input | 1 | With `wr_en`, write both bytes of `wr_data` |
| port_addr | input | 16 | I/O port address |
| wr_data | input | 16 | Write data; the upper byte is used only for word writes |
| rd_data | output | 8 | Byte returned by the most recent read |

## Verification
The assertions rely on two facts about the host. It never raises `rd_en` and `wr_en` in the same cycle. It keeps the cycle after a word write free, because that cycle carries the upper byte. The bench drives every access through one task per access kind. Each task drops the strobes at the next falling edge, and the word-write task adds the idle cycle itself, so no stimulus breaks either rule. Within those rules the checks cover the side effects that depend on ordering: the toggling of the attribute phase, the status flip, pointer increments and the CRT lock. All of them are observed through later reads at the ports.

// File: rtl/vshd_pkg.sv
package vshd_pkg;

  localparam int unsigned PORT_W    = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_BANKS = 4;

  // bank numbering used by the generate loop and the read mux
  localparam int unsigned BK_ATTR = 0;
  localparam int unsigned BK_SEQ  = 1;
  localparam int unsigned BK_GFX  = 2;
  localparam int unsigned BK_CRT  = 3;

  typedef enum logic [4:0] {
    PS_NONE,
    PS_ATTR_AD,   // shared attribute index/data port
    PS_ATTR_RD,   // attribute data read port
    PS_MISC_WR,
    PS_SEQ_IX,
    PS_SEQ_DT,
    PS_PEL_MASK,
    PS_DAC_RIX,
    PS_DAC_WIX,
    PS_DAC_DT,
    PS_MISC_RD,
    PS_GFX_IX,
    PS_GFX_DT,
    PS_CRT_IX,
    PS_CRT_DT,
    PS_STATUS
  } port_sel_e;

  typedef enum logic [1:0] {
    RS_HELD,
    RS_BANK,
    RS_DAC
  } rd_src_e;

endpackage

// File: rtl/vshd_port_decode.sv
module vshd_port_decode
  import vshd_pkg::*;
#(
  parameter logic [PORT_W-1:0] BASE = 16'h03C0
) (
  input  logic [PORT_W-1:0] port,
  output port_sel_e         sel
);

  localparam logic [PORT_W-1:0] SPAN = 16'h001A;

  logic [PORT_W-1:0] off;

  always_comb begin
    off = port - BASE;
    sel = PS_NONE;
    if (port >= BASE && off <= SPAN) begin
      case (off[4:0])
        5'h00:   sel = PS_ATTR_AD;
        5'h01:   sel = PS_ATTR_RD;
        5'h02:   sel = PS_MISC_WR;
        5'h04:   sel = PS_SEQ_IX;
        5'h05:   sel = PS_SEQ_DT;
        5'h06:   sel = PS_PEL_MASK;
        5'h07:   sel = PS_DAC_RIX;
        5'h08:   sel = PS_DAC_WIX;
        5'h09:   sel = PS_DAC_DT;
        5'h0C:   sel = PS_MISC_RD;
        5'h0E:   sel = PS_GFX_IX;
        5'h0F:   sel = PS_GFX_DT;
        5'h14:   sel = PS_CRT_IX;
        5'h15:   sel = PS_CRT_DT;
        5'h1A:   sel = PS_STATUS;
        default: sel = PS_NONE;
      endcase
    end
  end

endmodule

// File: rtl/vshd_idx_bank.sv
module vshd_idx_bank #(
  parameter int unsigned DEPTH  = 21,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ix_we,
  input  logic              dt_we,
  input  logic              dt_re,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ix_q,
  output logic              in_range,
  output logic [DATA_W-1:0] rd_q
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] regs [DEPTH];
  logic [AW-1:0]     addr;

  assign in_range = (32'(ix_q) < DEPTH);
  assign addr     = ix_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ix_q <= '0;
      rd_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) regs[i] <= '0;
    end else begin
      if (ix_we) ix_q <= wdata;
      if (dt_we && in_range) regs[addr] <= wdata;
      if (dt_re && in_range) rd_q <= regs[addr];
    end
  end

  AST_OOR_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (dt_re && !in_range) |=> $stable(rd_q)) else $error("out-of-range read loaded data"); // R7

  AST_INDEX_ONLY_ON_IX: assert property (@(posedge clk) disable iff (rst)
    !ix_we |=> $stable(ix_q)) else $error("index moved without index write"); // R6

endmodule

// File: rtl/vshd_dac.sv
module vshd_dac #(
  parameter int unsigned DEPTH  = 768,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SCALE  = 3,
  localparam int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_rp,
  input  logic              set_wp,
  input  logic              dt_we,
  input  logic              dt_re,
  input  logic [DATA_W-1:0] val,
  output logic [PTR_W-1:0]  rp,
  output logic [PTR_W-1:0]  wp,
  output logic              rd_ok,
  output logic [DATA_W-1:0] rd_q
);

  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);

  logic [DATA_W-1:0] table_mem [DEPTH];
  logic [PTR_W-1:0]  scaled;
  logic              wr_ok;

  assign scaled = PTR_W'(val) * PTR_W'(SCALE);
  assign rd_ok  = (rp < LIMIT);
  assign wr_ok  = (wp < LIMIT);

  // contents carry no reset so the array maps onto block RAM
  always_ff @(posedge clk) begin
    if (dt_we && wr_ok) table_mem[wp] <= val;
    if (dt_re && rd_ok) rd_q <= table_mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rp <= '0;
      wp <= '0;
    end else begin
      if (set_rp)              rp <= scaled;
      else if (dt_re && rd_ok) rp <= rp + 1'b1;
      if (set_wp)              wp <= scaled;
      else if (dt_we && wr_ok) wp <= wp + 1'b1;
    end
  end

  AST_WP_BOUND: assert property (@(posedge clk) disable iff (rst)
    wp <= LIMIT) else $error("write pointer past table end"); // R11

  AST_RP_BOUND: assert property (@(posedge clk) disable iff (rst)
    rp <= LIMIT) else $error("read pointer past table end"); // R11

  AST_WP_STEP: assert property (@(posedge clk) disable iff (rst)
    (dt_we && wr_ok && !set_wp) |=> (wp == $past(wp) + 1'b1)) else $error("write pointer did not step"); // R11

  AST_RP_HOLD_AT_END: assert property (@(posedge clk) disable iff (rst)
    (dt_re && !rd_ok && !set_rp) |=> $stable(rp)) else $error("read pointer moved at table end"); // R11

endmodule

// File: rtl/vga_reg_shadow.sv
module vga_reg_shadow
  import vshd_pkg::*;
#(
  parameter logic [15:0] PORT_BASE     = 16'h03C0,
  parameter int unsigned ATTR_DEPTH    = 21,
  parameter int unsigned SEQ_DEPTH     = 5,
  parameter int unsigned GFX_DEPTH     = 9,
  parameter int unsigned CRT_DEPTH     = 25,
  parameter int unsigned DAC_DEPTH     = 768,
  parameter int unsigned DAC_SCALE     = 3,
  parameter logic [7:0]  STATUS_TOGGLE = 8'h09,
  parameter logic [7:0]  UNMAPPED      = 8'hFF,
  parameter int unsigned CRT_EN_BIT    = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic        wr_word,
  input  logic [15:0] port_addr,
  input  logic [15:0] wr_data,
  output logic [7:0]  rd_data
);

  localparam int unsigned PTR_W = $clog2(DAC_DEPTH + 1);

  // ---------------- word write split ----------------
  logic        hi_pend;
  logic [15:0] hi_port;
  logic [7:0]  hi_data;
  logic        op_wr, op_rd;
  logic [15:0] op_port;
  logic [7:0]  op_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_pend <= 1'b0;
      hi_port <= '0;
      hi_data <= '0;
    end else begin
      hi_pend <= wr_en && wr_word && !hi_pend;
      hi_port <= port_addr + 16'd1;
      hi_data <= wr_data[15:8];
    end
  end

  assign op_wr   = hi_pend || wr_en;
  assign op_rd   = rd_en && !hi_pend;
  assign op_port = hi_pend ? hi_port : port_addr;
  assign op_data = hi_pend ? hi_data : wr_data[7:0];

  // ---------------- decode ----------------
  port_sel_e sel;

  vshd_port_decode #(.BASE(PORT_BASE)) u_decode (
    .port (op_port),
    .sel  (sel)
  );

  // ---------------- scalar registers ----------------
  logic       attr_ph;
  logic [7:0] misc_q, mask_q, status_q;
  logic       crt_on;

  assign crt_on = misc_q[CRT_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_ph  <= 1'b0;
      misc_q   <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (op_rd && sel == PS_STATUS) begin
        attr_ph  <= 1'b0;
        status_q <= status_q ^ STATUS_TOGGLE;
      end else if ((op_rd || op_wr) && sel == PS_ATTR_AD) begin
        attr_ph <= ~attr_ph;
      end
      if (op_wr && sel == PS_MISC_WR)  misc_q <= op_data;
      if (op_wr && sel == PS_PEL_MASK) mask_q <= op_data;
    end
  end

  // ---------------- indexed banks ----------------
  logic       bk_ix_we [NUM_BANKS];
  logic       bk_dt_we [NUM_BANKS];
  logic       bk_dt_re [NUM_BANKS];
  logic [7:0] bk_ix    [NUM_BANKS];
  logic       bk_ok    [NUM_BANKS];
  logic [7:0] bk_rd    [NUM_BANKS];

  always_comb begin
    bk_ix_we[BK_ATTR] = op_wr && sel == PS_ATTR_AD && !attr_ph;
    bk_dt_we[BK_ATTR] = op_wr && sel == PS_ATTR_AD &&  attr_ph;
    bk_dt_re[BK_ATTR] = op_rd && ((sel == PS_ATTR_AD && attr_ph) || sel == PS_ATTR_RD);

    bk_ix_we[BK_SEQ]  = op_wr && sel == PS_SEQ_IX;
    bk_dt_we[BK_SEQ]  = op_wr && sel == PS_SEQ_DT;
    bk_dt_re[BK_SEQ]  = op_rd && sel == PS_SEQ_DT;

    bk_ix_we[BK_GFX]  = op_wr && sel == PS_GFX_IX;
    bk_dt_we[BK_GFX]  = op_wr && sel == PS_GFX_DT;
    bk_dt_re[BK_GFX]  = op_rd && sel == PS_GFX_DT;

    bk_ix_we[BK_CRT]  = op_wr && sel == PS_CRT_IX && crt_on;
    bk_dt_we[BK_CRT]  = op_wr && sel == PS_CRT_DT && crt_on;
    bk_dt_re[BK_CRT]  = op_rd && sel == PS_CRT_DT && crt_on;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam int unsigned D = (g == BK_ATTR) ? ATTR_DEPTH :
                                (g == BK_SEQ)  ? SEQ_DEPTH  :
                                (g == BK_GFX)  ? GFX_DEPTH  : CRT_DEPTH;
    vshd_idx_bank #(.DEPTH(D), .DATA_W(8)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .ix_we    (bk_ix_we[g]),
      .dt_we    (bk_dt_we[g]),
      .dt_re    (bk_dt_re[g]),
      .wdata    (op_data),
      .ix_q     (bk_ix[g]),
      .in_range (bk_ok[g]),
      .rd_q     (bk_rd[g])
    );
  end

  // ---------------- colour table ----------------
  logic [PTR_W-1:0] dac_rp, dac_wp;
  logic             dac_rd_ok;
  logic [7:0]       dac_rd;

  vshd_dac #(.DEPTH(DAC_DEPTH), .DATA_W(8), .SCALE(DAC_SCALE)) u_dac (
    .clk    (clk),
    .rst    (rst),
    .set_rp (op_wr && sel == PS_DAC_RIX),
    .set_wp (op_wr && sel == PS_DAC_WIX),
    .dt_we  (op_wr && sel == PS_DAC_DT),
    .dt_re  (op_rd && sel == PS_DAC_DT),
    .val    (op_data),
    .rp     (dac_rp),
    .wp     (dac_wp),
    .rd_ok  (dac_rd_ok),
    .rd_q   (dac_rd)
  );

  // ---------------- read return ----------------
  rd_src_e    nxt_src, src_q;
  logic [1:0] nxt_bank, bank_q;
  logic [7:0] nxt_val, held_q;

  always_comb begin
    nxt_src  = RS_HELD;
    nxt_bank = 2'(BK_ATTR);
    nxt_val  = UNMAPPED;
    case (sel)
      PS_ATTR_AD: begin
        if (!attr_ph) nxt_val = bk_ix[BK_ATTR];
        else if (bk_ok[BK_ATTR]) nxt_src = RS_BANK;
      end
      PS_ATTR_RD: if (bk_ok[BK_ATTR]) nxt_src = RS_BANK;
      PS_SEQ_IX:  nxt_val = bk_ix[BK_SEQ];
      PS_SEQ_DT: begin
        nxt_bank = 2'(BK_SEQ);
        if (bk_ok[BK_SEQ]) nxt_src = RS_BANK;
      end
      PS_GFX_IX:  nxt_val = bk_ix[BK_GFX];
      PS_GFX_DT: begin
        nxt_bank = 2'(BK_GFX);
        if (bk_ok[BK_GFX]) nxt_src = RS_BANK;
      end
      PS_CRT_IX:  if (crt_on) nxt_val = bk_ix[BK_CRT];
      PS_CRT_DT: begin
        nxt_bank = 2'(BK_CRT);
        if (crt_on && bk_ok[BK_CRT]) nxt_src = RS_BANK;
      end
      PS_MISC_RD:  nxt_val = misc_q;
      PS_PEL_MASK: nxt_val = mask_q;
      PS_DAC_RIX:  nxt_val = dac_rp[7:0];
      PS_DAC_WIX:  nxt_val = dac_wp[7:0];
      PS_DAC_DT:   if (dac_rd_ok) nxt_src = RS_DAC;
      PS_STATUS:   nxt_val = status_q;
      default:     nxt_val = UNMAPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= RS_HELD;
      bank_q <= '0;
      held_q <= '0;
    end else if (op_rd) begin
      src_q  <= nxt_src;
      bank_q <= nxt_bank;
      held_q <= nxt_val;
    end
  end

  always_comb begin
    case (src_q)
      RS_BANK: rd_data = bk_rd[bank_q];
      RS_DAC:  rd_data = dac_rd;
      default: rd_data = held_q;
    endcase
  end

  // ---------------- assertions ----------------
  AST_NO_RD_WR_CLASH: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en)) else $error("read and write in one cycle"); // R13

  AST_WORD_GAP: assert property (@(posedge clk) disable iff (rst)
    hi_pend |-> (!wr_en && !rd_en)) else $error("access in word-write gap"); // R13

  AST_HI_PORT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word && !hi_pend) |=> (op_port == $past(port_addr) + 16'd1)) else $error("upper byte port wrong"); // R13

  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    ((op_rd || op_wr) && sel == PS_ATTR_AD) |=> (attr_ph != $past(attr_ph))) else $error("attribute phase did not toggle"); // R3

  AST_PHASE_HOLD_RD: assert property (@(posedge clk) disable iff (rst)
    (op_rd && sel == PS_ATTR_RD) |=> $stable(attr_ph)) else $error("0x3C1 read toggled phase"); // R4

  AST_STATUS_CLEARS_PHASE: assert property (@(posedge clk) disable iff (rst)
    (op_rd && sel == PS_STATUS) |=> !attr_ph) else $error("status read kept phase"); // R5

  AST_STATUS_FLIP: assert property (@(posedge clk) disable iff (rst)
    (op_rd && sel == PS_STATUS) |=> (status_q == ($past(status_q) ^ STATUS_TOGGLE))) else $error("status did not flip"); // R5

  AST_CRT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (op_wr && sel == PS_CRT_IX && !crt_on) |=> $stable(bk_ix[BK_CRT])) else $error("CRT index written while locked"); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_rd |=> ($stable(src_q) && $stable(held_q))) else $error("read source changed without a read"); // R2

endmodule

// File: tb/test_vga_reg_shadow.sv
module test_vga_reg_shadow;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en, wr_word;
  logic [15:0] port_addr, wr_data;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vga_reg_shadow i_vga_reg_shadow (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_word   (wr_word),
    .port_addr (port_addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 200000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] p, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_word = 1'b0; port_addr = p; wr_data = {8'h00, d};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic io_wr16(input logic [15:0] p, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_word = 1'b1; port_addr = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_word = 1'b0;
    @(negedge clk);  // idle cycle carrying the upper byte
  endtask

  task automatic io_rd(input logic [15:0] p, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; port_addr = p;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] p, input logic [7:0] exp);
    logic [7:0] v;
    io_rd(p, v);
    chk(req, $sformatf("port %03h", p), v, exp);
  endtask

  task automatic t_reset();
    chk("R1", "rd_data after reset", rd_data, 8'h00);
    rd_chk("R1", 16'h03C4, 8'h00);
    rd_chk("R1", 16'h03CC, 8'h00);
    rd_chk("R1", 16'h03C6, 8'h00);
    rd_chk("R1", 16'h03C7, 8'h00);
    rd_chk("R1", 16'h03C8, 8'h00);
    rd_chk("R1", 16'h03CE, 8'h00);
  endtask

  task automatic t_status();
    rd_chk("R5", 16'h03DA, 8'h00);
    rd_chk("R5", 16'h03DA, 8'h09);
    rd_chk("R5", 16'h03DA, 8'h00);
  endtask

  task automatic t_attr();
    logic [7:0] v;
    io_rd(16'h03DA, v);               // phase to index
    io_wr(16'h03C0, 8'h05);           // index
    io_wr(16'h03C0, 8'hA5);           // data
    rd_chk("R4", 16'h03C1, 8'hA5);
    rd_chk("R4", 16'h03C1, 8'hA5);    // no toggle: still data read
    rd_chk("R3", 16'h03C0, 8'h05);    // index phase read
    rd_chk("R3", 16'h03C0, 8'hA5);    // data phase read
    rd_chk("R2", 16'h03C6, 8'h00);
    chk("R2", "rd_data held", rd_data, 8'h00);
    io_wr(16'h03C1, 8'h33);           // ignored
    rd_chk("R4", 16'h03C1, 8'hA5);
    io_wr(16'h03C0, 8'h07);           // index 7, phase now data
    io_rd(16'h03DA, v);               // clears phase
    io_wr(16'h03C0, 8'h0A);           // must be index again
    rd_chk("R5", 16'h03C1, 8'h00);    // entry 10 untouched
    io_wr(16'h03C0, 8'h0B);           // data into entry 10
    rd_chk("R5", 16'h03C1, 8'h0B);
    // out of range attribute index
    io_rd(16'h03DA, v);
    io_wr(16'h03C0, 8'h15);
    io_wr(16'h03C0, 8'h77);
    rd_chk("R7", 16'h03C1, 8'hFF);
    rd_chk("R7", 16'h03C0, 8'h15);
    rd_chk("R7", 16'h03C0, 8'hFF);
  endtask

  task automatic t_seqgfx();
    io_wr(16'h03C4, 8'h02); io_wr(16'h03C5, 8'h5A);
    io_wr(16'h03CE, 8'h08); io_wr(16'h03CF, 8'hC3);
    rd_chk("R6", 16'h03C5, 8'h5A);
    rd_chk("R6", 16'h03CF, 8'hC3);
    rd_chk("R6", 16'h03C4, 8'h02);
    rd_chk("R6", 16'h03CE, 8'h08);
    io_wr(16'h03C4, 8'h05); io_wr(16'h03C5, 8'h11);
    rd_chk("R7", 16'h03C5, 8'hFF);
    io_wr(16'h03C4, 8'h02);
    rd_chk("R7", 16'h03C5, 8'h5A);
    io_wr(16'h03CE, 8'h09); io_wr(16'h03CF, 8'h44);
    rd_chk("R7", 16'h03CF, 8'hFF);
    io_wr(16'h03CE, 8'h08);
    rd_chk("R7", 16'h03CF, 8'hC3);
  endtask

  task automatic t_misc();
    io_wr(16'h03C2, 8'h67);
    rd_chk("R8", 16'h03CC, 8'h67);
    io_wr(16'h03C6, 8'hF0);
    rd_chk("R8", 16'h03C6, 8'hF0);
    io_wr(16'h03CC, 8'h12);           // read-only port
    rd_chk("R12", 16'h03CC, 8'h67);
  endtask

  task automatic t_crt();
    io_wr(16'h03C2, 8'h66);
    io_wr(16'h03D4, 8'h03);
    rd_chk("R9", 16'h03D4, 8'hFF);
    io_wr(16'h03C2, 8'h67);
    rd_chk("R9", 16'h03D4, 8'h00);
    io_wr(16'h03D4, 8'h03); io_wr(16'h03D5, 8'h9C);
    rd_chk("R9", 16'h03D5, 8'h9C);
    io_wr(16'h03C2, 8'h66);
    io_wr(16'h03D5, 8'h11);
    rd_chk("R9", 16'h03D5, 8'hFF);
    io_wr(16'h03C2, 8'h67);
    rd_chk("R9", 16'h03D5, 8'h9C);
    io_wr(16'h03D4, 8'h18); io_wr(16'h03D5, 8'h4E);
    rd_chk("R7", 16'h03D5, 8'h4E);
    io_wr(16'h03D4, 8'h19); io_wr(16'h03D5, 8'h22);
    rd_chk("R7", 16'h03D5, 8'hFF);
  endtask

  task automatic t_dac();
    io_wr(16'h03C8, 8'h02);
    rd_chk("R10", 16'h03C8, 8'h06);
    io_wr(16'h03C9, 8'h11); io_wr(16'h03C9, 8'h22); io_wr(16'h03C9, 8'h33);
    rd_chk("R11", 16'h03C8, 8'h09);
    io_wr(16'h03C7, 8'h02);
    rd_chk("R10", 16'h03C7, 8'h06);
    rd_chk("R11", 16'h03C9, 8'h11);
    rd_chk("R11", 16'h03C9, 8'h22);
    rd_chk("R11", 16'h03C9, 8'h33);
    rd_chk("R11", 16'h03C7, 8'h09);
    io_wr(16'h03C8, 8'hFF);
    rd_chk("R10", 16'h03C8, 8'hFD);
    for (int k = 0; k < 4; k++) io_wr(16'h03C9, 8'hA1 + 8'(k));
    rd_chk("R11", 16'h03C8, 8'h00);   // stopped at 768
    io_wr(16'h03C7, 8'hFF);
    rd_chk("R11", 16'h03C9, 8'hA1);
    rd_chk("R11", 16'h03C9, 8'hA2);
    rd_chk("R11", 16'h03C9, 8'hA3);
    rd_chk("R11", 16'h03C9, 8'hFF);
    rd_chk("R11", 16'h03C7, 8'h00);
  endtask

  task automatic t_other();
    rd_chk("R12", 16'h03C2, 8'hFF);
    rd_chk("R12", 16'h03CA, 8'hFF);
    rd_chk("R12", 16'h0080, 8'hFF);
    io_wr(16'h03DB, 8'h01);
    io_wr(16'h03BF, 8'h04);
    rd_chk("R12", 16'h03C4, 8'h02);
    rd_chk("R12", 16'h03CC, 8'h67);
  endtask

  task automatic t_word();
    io_wr16(16'h03C4, 16'hBE01);
    rd_chk("R13", 16'h03C4, 8'h01);
    rd_chk("R13", 16'h03C5, 8'hBE);
    io_wr16(16'h03C8, 16'h5504);
    rd_chk("R13", 16'h03C8, 8'h0D);
    io_wr(16'h03C7, 8'h04);
    rd_chk("R13", 16'h03C9, 8'h55);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; wr_word = 1'b0;
    port_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_status();
    t_attr();
    t_seqgfx();
    t_misc();
    t_crt();
    t_dac();
    t_other();
    t_word();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule